// File: doc/BRIEF.md
# Background CRC Memory Scrubber

This block runs an endless integrity sweep over a configuration memory that was loaded at start-up. Each memory frame is a fixed number of words. Every frame has a 16-bit check value, computed when the memory was loaded and kept in a separate check memory. The scrubber reads the frames one word at a time, computes each frame's CRC again, and compares the result with the stored value. A difference means that at least one stored bit has flipped. The block reports this as a soft-error event and keeps sweeping. The block does not correct the error.

The sweep runs only while the device is in its operating mode and the scrub option is enabled. It is paced by a clock-enable strobe, not by a derived clock. The strobe divides the local clock by a power of two, selected with a 3-bit code that covers factors 2 to 256. Both memories respond to a read strobe with one cycle of latency.

Top module: `crc_scrub_top`

## Requirements
- R1: Read strobes (`frm_rd`) are issued only while `user_mode` and `scrub_en` are both high. When either input drops, the sweep stops. The next start begins again at frame 0, word 0. `scan_active` follows the AND of the two inputs with one cycle of delay.
- R2: While the sweep runs, consecutive `frm_rd` strobes are exactly 2^(`div_sel`+1) clock cycles apart: code 0 gives 2 cycles and code 7 gives 256 cycles. Each strobe is one cycle long.
- R3: `frm_addr` steps through the values frame*WORDS_PER_FRAME+word in ascending order and returns to 0 after the last word of the last frame. `chk_rd` is high together with `frm_rd` only on the last word of a frame, and `chk_addr` then holds that frame's index.
- R4: The frame CRC uses the polynomial 0x8005 with initial value 0xFFFF. Words are fed most significant bit first, with no reflection and no final XOR. A frame whose CRC equals its check word raises no error.
- R5: On a mismatch, `err_pulse` is high for one cycle. `err_flag` sets and stays set until reset. `err_frame` takes the index of the most recent failing frame.
- R6: Scanning continues after an error and repeats pass after pass. A frame that has been repaired raises no further pulses, but the flag stays set.
- R7: `pass_done` pulses for one cycle once per complete pass, in the cycle in which the last frame's comparison result appears.
- R8: During and after reset, all outputs are 0.
- R9: Memory data is taken one cycle after the read strobe. The comparison is made one cycle after the last word has been consumed, so `err_pulse` and `pass_done` appear exactly 3 cycles after the `chk_rd` strobe of that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low synchronous reset |
| user_mode | input | 1 | Device has entered operating mode |
| scrub_en | input | 1 | Scrub option enable |
| div_sel | input | 3 | Divide code n; the strobe period is 2^(n+1) cycles |
| frm_rd | output | 1 | Frame memory read strobe |
| frm_addr | output | 5 | Linear frame-memory word address |
| frm_data | input | 16 | Frame memory read data, valid one cycle after `frm_rd` |
| chk_rd | output | 1 | Check memory read strobe |
| chk_addr | output | 3 | Frame index for the check memory |
| chk_data | input | 16 | Stored check value, valid one cycle after `chk_rd` |
| scan_active | output | 1 | Sweep enabled (registered) |
| pass_done | output | 1 | One-cycle pulse at the end of each pass |
| err_pulse | output | 1 | One-cycle pulse for each mismatching frame |
| err_flag | output | 1 | Sticky mismatch flag |
| err_frame | output | 3 | Index of the latest failing frame |

## Verification
The sweep is run over clean memory images built from different seeds, and over images with a single flipped bit in the first frame, the last frame and frames in the middle. The clean images show that the CRC definition is right. The flipped images show that the failing frame index is captured correctly at both ends of the frame range. Divide codes from the fastest to the slowest are combined with these images, so that strobe spacing and address order are checked at each speed. Further tests cover:
- two corrupted frames, to separate latest-frame capture from first-frame capture;
- a repair between passes, to separate the sticky flag from the per-frame pulse;
- a stop in the middle of a pass, to show that the restart begins at address 0 and that no stale partial CRC is compared.

// File: rtl/scrub_pkg.sv
package scrub_pkg;

    localparam int unsigned DIV_SEL_W = 3;
    localparam int unsigned DIV_CNT_W = 8;
    localparam int unsigned CRC_W     = 16;

    // Terminal count of the divide counter: factor 2^(sel+1), minus one.
    function automatic logic [DIV_CNT_W-1:0] div_limit(input logic [DIV_SEL_W-1:0] sel);
        logic [DIV_CNT_W:0] factor;
        factor = (DIV_CNT_W+1)'(2) << sel;
        return DIV_CNT_W'(factor - (DIV_CNT_W+1)'(1));
    endfunction

    // One serial CRC step, most significant bit first.
    function automatic logic [CRC_W-1:0] crc_bit(input logic [CRC_W-1:0] c,
                                                  input logic             b,
                                                  input logic [CRC_W-1:0] poly);
        logic fb;
        fb = c[CRC_W-1] ^ b;
        return {c[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
    endfunction

endpackage

// File: rtl/scrub_tick_gen.sv
module scrub_tick_gen
    import scrub_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run,
    input  logic [DIV_SEL_W-1:0] div_sel,
    output logic                 tick
);

    typedef struct packed {
        logic [DIV_CNT_W-1:0] cnt;
        logic                 tick;
    } tg_state_t;

    tg_state_t st_d, st_q;
    logic [DIV_CNT_W-1:0] lim;
    logic                 at_lim;

    always_comb begin
        st_d   = st_q;
        lim    = div_limit(div_sel);
        at_lim = (st_q.cnt >= lim);
        if (!run) begin
            st_d.cnt  = '0;
            st_d.tick = 1'b0;
        end else begin
            st_d.tick = at_lim;
            st_d.cnt  = at_lim ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick = st_q.tick;

endmodule

// File: rtl/scrub_seq.sv
module scrub_seq #(
    parameter int NUM_FRAMES      = 6,
    parameter int WORDS_PER_FRAME = 4,
    parameter int FRM_AW          = 5,
    parameter int FA_W            = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    output logic              rd,
    output logic [FRM_AW-1:0] addr,
    output logic              first,
    output logic              last,
    output logic              chk_rd,
    output logic [FA_W-1:0]   frame
);

    localparam int TOTAL = NUM_FRAMES * WORDS_PER_FRAME;
    localparam int WI_W  = (WORDS_PER_FRAME > 1) ? $clog2(WORDS_PER_FRAME) : 1;
    localparam logic [FRM_AW-1:0] LIN_LAST  = FRM_AW'(TOTAL - 1);
    localparam logic [WI_W-1:0]   WORD_LAST = WI_W'(WORDS_PER_FRAME - 1);
    localparam logic [FA_W-1:0]   FRM_LAST  = FA_W'(NUM_FRAMES - 1);

    typedef struct packed {
        logic [FRM_AW-1:0] lin;
        logic [WI_W-1:0]   word;
        logic [FA_W-1:0]   frm;
        logic              rd;
        logic [FRM_AW-1:0] addr;
        logic              first;
        logic              last;
        logic              chk_rd;
        logic [FA_W-1:0]   iss_frm;
    } seq_state_t;

    seq_state_t st_d, st_q;
    logic       word_end;

    always_comb begin
        st_d        = st_q;
        st_d.rd     = 1'b0;
        st_d.chk_rd = 1'b0;
        word_end    = (st_q.word == WORD_LAST);
        if (!run) begin
            st_d = '0;
        end else if (tick) begin
            st_d.rd      = 1'b1;
            st_d.addr    = st_q.lin;
            st_d.first   = (st_q.word == '0);
            st_d.last    = word_end;
            st_d.chk_rd  = word_end;
            st_d.iss_frm = st_q.frm;
            st_d.lin     = (st_q.lin == LIN_LAST) ? '0 : st_q.lin + 1'b1;
            st_d.word    = word_end ? '0 : st_q.word + 1'b1;
            if (word_end)
                st_d.frm = (st_q.frm == FRM_LAST) ? '0 : st_q.frm + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd     = st_q.rd;
    assign addr   = st_q.addr;
    assign first  = st_q.first;
    assign last   = st_q.last;
    assign chk_rd = st_q.chk_rd;
    assign frame  = st_q.iss_frm;

endmodule

// File: rtl/scrub_crc.sv
module scrub_crc
    import scrub_pkg::*;
#(
    parameter int               WORD_W = 16,
    parameter int               FA_W   = 3,
    parameter logic [CRC_W-1:0] POLY   = 16'h8005,
    parameter logic [CRC_W-1:0] INIT   = 16'hFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              rd,
    input  logic              first,
    input  logic              last,
    input  logic [FA_W-1:0]   frame,
    input  logic [WORD_W-1:0] data,
    output logic              done,
    output logic [CRC_W-1:0]  crc,
    output logic [FA_W-1:0]   done_frame
);

    typedef struct packed {
        logic             vld;
        logic             first;
        logic             last;
        logic [FA_W-1:0]  frm;
        logic [CRC_W-1:0] crc;
        logic             done;
        logic [FA_W-1:0]  dfrm;
    } crc_state_t;

    crc_state_t       st_d, st_q;
    logic [CRC_W-1:0] acc;

    always_comb begin
        st_d       = st_q;
        // stage 1: remember the beat whose data returns next cycle
        st_d.vld   = run && rd;
        st_d.first = first;
        st_d.last  = last;
        st_d.frm   = frame;
        // stage 2: fold the returned word into the running CRC
        st_d.done  = 1'b0;
        acc        = st_q.first ? INIT : st_q.crc;
        for (int i = WORD_W - 1; i >= 0; i--)
            acc = crc_bit(acc, data[i], POLY);
        if (run && st_q.vld) begin
            st_d.crc  = acc;
            st_d.done = st_q.last;
            st_d.dfrm = st_q.frm;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done       = st_q.done;
    assign crc        = st_q.crc;
    assign done_frame = st_q.dfrm;

endmodule

// File: rtl/crc_scrub_top.sv
module crc_scrub_top
    import scrub_pkg::*;
#(
    parameter int               NUM_FRAMES      = 6,
    parameter int               WORDS_PER_FRAME = 4,
    parameter int               WORD_W          = 16,
    parameter logic [CRC_W-1:0] POLY            = 16'h8005,
    parameter logic [CRC_W-1:0] INIT            = 16'hFFFF,
    localparam int              TOTAL           = NUM_FRAMES * WORDS_PER_FRAME,
    localparam int              FRM_AW          = (TOTAL > 1) ? $clog2(TOTAL) : 1,
    localparam int              FA_W            = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 user_mode,
    input  logic                 scrub_en,
    input  logic [DIV_SEL_W-1:0] div_sel,
    output logic                 frm_rd,
    output logic [FRM_AW-1:0]    frm_addr,
    input  logic [WORD_W-1:0]    frm_data,
    output logic                 chk_rd,
    output logic [FA_W-1:0]      chk_addr,
    input  logic [CRC_W-1:0]     chk_data,
    output logic                 scan_active,
    output logic                 pass_done,
    output logic                 err_pulse,
    output logic                 err_flag,
    output logic [FA_W-1:0]      err_frame
);

    localparam logic [FA_W-1:0] FRM_LAST = FA_W'(NUM_FRAMES - 1);

    logic             run;
    logic             tick;
    logic             seq_first, seq_last;
    logic [FA_W-1:0]  seq_frame;
    logic             cmp_go;
    logic [CRC_W-1:0] cmp_crc;
    logic [FA_W-1:0]  cmp_frame;

    assign run = user_mode && scrub_en;

    scrub_tick_gen u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .div_sel (div_sel),
        .tick    (tick)
    );

    scrub_seq #(
        .NUM_FRAMES      (NUM_FRAMES),
        .WORDS_PER_FRAME (WORDS_PER_FRAME),
        .FRM_AW          (FRM_AW),
        .FA_W            (FA_W)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .tick   (tick),
        .rd     (frm_rd),
        .addr   (frm_addr),
        .first  (seq_first),
        .last   (seq_last),
        .chk_rd (chk_rd),
        .frame  (seq_frame)
    );

    assign chk_addr = seq_frame;

    scrub_crc #(
        .WORD_W (WORD_W),
        .FA_W   (FA_W),
        .POLY   (POLY),
        .INIT   (INIT)
    ) u_crc (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .rd         (frm_rd),
        .first      (seq_first),
        .last       (seq_last),
        .frame      (seq_frame),
        .data       (frm_data),
        .done       (cmp_go),
        .crc        (cmp_crc),
        .done_frame (cmp_frame)
    );

    typedef struct packed {
        logic            active;
        logic            pass_done;
        logic            err_pulse;
        logic            err_flag;
        logic [FA_W-1:0] err_frame;
    } rep_state_t;

    rep_state_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.active    = run;
        st_d.pass_done = 1'b0;
        st_d.err_pulse = 1'b0;
        if (cmp_go) begin
            if (cmp_crc != chk_data) begin
                st_d.err_pulse = 1'b1;
                st_d.err_flag  = 1'b1;
                st_d.err_frame = cmp_frame;
            end
            st_d.pass_done = (cmp_frame == FRM_LAST);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign scan_active = st_q.active;
    assign pass_done   = st_q.pass_done;
    assign err_pulse   = st_q.err_pulse;
    assign err_flag    = st_q.err_flag;
    assign err_frame   = st_q.err_frame;

endmodule

// File: rtl/scrub_chk.sv
module scrub_chk (
    input logic clk,
    input logic rst_n,
    input logic user_mode,
    input logic scrub_en,
    input logic frm_rd,
    input logic chk_rd,
    input logic pass_done,
    input logic err_pulse,
    input logic err_flag
);

    // R1
    rd_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_rd |-> $past(user_mode && scrub_en));

    // R2
    rd_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_rd |=> !frm_rd);

    // R3
    chk_with_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_rd |-> frm_rd);

    // R5
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(err_flag) |-> err_flag);

    // R5
    pulse_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> err_flag);

    // R7
    pass_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pass_done |=> !pass_done);

    // R9
    err_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> $past(chk_rd, 3));

    // R7
    pass_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pass_done |-> $past(chk_rd, 3));

endmodule

bind crc_scrub_top scrub_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .user_mode (user_mode),
    .scrub_en  (scrub_en),
    .frm_rd    (frm_rd),
    .chk_rd    (chk_rd),
    .pass_done (pass_done),
    .err_pulse (err_pulse),
    .err_flag  (err_flag)
);

// File: tb/crc_scrub_top_tb.sv
module crc_scrub_top_tb;

    localparam int NF    = 6;
    localparam int WPF   = 4;
    localparam int TOTAL = NF * WPF;
    localparam int NONE  = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        user_mode = 1'b0;
    logic        scrub_en = 1'b0;
    logic [2:0]  div_sel = 3'd0;
    logic        frm_rd, chk_rd;
    logic [4:0]  frm_addr;
    logic [2:0]  chk_addr;
    logic [15:0] frm_data, chk_data;
    logic        scan_active, pass_done, err_pulse, err_flag;
    logic [2:0]  err_frame;

    logic [15:0] fmem [TOTAL];
    logic [15:0] cmem [NF];

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    crc_scrub_top u_dut (
        .clk(clk), .rst_n(rst_n), .user_mode(user_mode), .scrub_en(scrub_en),
        .div_sel(div_sel), .frm_rd(frm_rd), .frm_addr(frm_addr), .frm_data(frm_data),
        .chk_rd(chk_rd), .chk_addr(chk_addr), .chk_data(chk_data),
        .scan_active(scan_active), .pass_done(pass_done), .err_pulse(err_pulse),
        .err_flag(err_flag), .err_frame(err_frame)
    );

    // memories with one cycle of read latency
    always @(posedge clk) begin
        if (frm_rd) frm_data <= fmem[frm_addr];
        if (chk_rd) chk_data <= cmem[chk_addr];
    end

    // monitor, sampled at the falling edge
    int cyc = 0, rd_cnt = 0, pass_cnt = 0, pulse_cnt = 0;
    int addr_err = 0, gap_err = 0, lat_err = 0;
    int exp_addr = 0, last_rd = 0, last_chk = -100, last_chk_frm = 0;
    bit have_prev = 0;

    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            rd_cnt = 0; pass_cnt = 0; pulse_cnt = 0;
            addr_err = 0; gap_err = 0; lat_err = 0;
            exp_addr = 0; have_prev = 0; last_chk = -100;
        end else begin
            if (frm_rd) begin
                rd_cnt++;
                if (int'(frm_addr) != exp_addr) addr_err++;
                if (chk_rd != ((exp_addr % WPF) == WPF - 1)) addr_err++;
                if (chk_rd && int'(chk_addr) != exp_addr / WPF) addr_err++;
                exp_addr = (exp_addr + 1) % TOTAL;
                if (have_prev && (cyc - last_rd) != (1 << (int'(div_sel) + 1))) gap_err++;
                have_prev = 1;
                last_rd = cyc;
            end
            if (chk_rd) begin
                last_chk = cyc;
                last_chk_frm = int'(chk_addr);
            end
            if (err_pulse) begin
                pulse_cnt++;
                if (cyc - last_chk != 3) lat_err++;
            end
            if (pass_done) begin
                pass_cnt++;
                if (cyc - last_chk != 3 || last_chk_frm != NF - 1) lat_err++;
            end
            if (!(user_mode && scrub_en)) begin
                exp_addr = 0;
                have_prev = 0;
            end
        end
    end

    task automatic summary_and_end();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // watchdog
    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 190000) begin
            errors++;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 190000", wd);
            summary_and_end();
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // reference CRC: poly 0x8005, init 0xFFFF, MSB first
    function automatic logic [15:0] ref_crc(input int f);
        logic [15:0] c = 16'hFFFF;
        for (int w = 0; w < WPF; w++) begin
            for (int b = 15; b >= 0; b--) begin
                logic fb;
                fb = c[15] ^ fmem[f * WPF + w][b];
                c = {c[14:0], 1'b0};
                if (fb) c = c ^ 16'h8005;
            end
        end
        return c;
    endfunction

    task automatic load(input int seed);
        for (int i = 0; i < TOTAL; i++)
            fmem[i] = 16'((i * 16'h3A7) ^ (seed * 16'h1F1) ^ (i << 9));
        for (int f = 0; f < NF; f++) cmem[f] = ref_crc(f);
    endtask

    task automatic flip(input int f, input int b);
        fmem[f * WPF + 1][b] = ~fmem[f * WPF + 1][b];
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst_n = 1'b0; user_mode = 1'b0; scrub_en = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic start(input int sel);
        @(posedge clk); #1;
        div_sel = 3'(sel); user_mode = 1'b1; scrub_en = 1'b1;
    endtask

    task automatic wait_passes(input int n);
        int t = 0;
        while (pass_cnt < n && t < 20000) begin
            @(posedge clk); #3;
            t++;
        end
        check("R7", "pass reached", int'(pass_cnt >= n), 1);
    endtask

    typedef struct packed {
        logic [2:0] sel;
        logic [7:0] seed;
        logic [3:0] flip_frm;
        logic [3:0] flip_bit;
        logic       exp_err;
        logic [2:0] exp_frm;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{3'd0, 8'd1, 4'd15, 4'd0,  1'b0, 3'd0},
        '{3'd1, 8'd2, 4'd0,  4'd0,  1'b1, 3'd0},
        '{3'd3, 8'd3, 4'd5,  4'd15, 1'b1, 3'd5},
        '{3'd7, 8'd4, 4'd15, 4'd0,  1'b0, 3'd0},
        '{3'd2, 8'd5, 4'd3,  4'd7,  1'b1, 3'd3},
        '{3'd5, 8'd6, 4'd2,  4'd9,  1'b1, 3'd2}
    };

    initial begin
        // R8: reset state
        load(0);
        repeat (2) @(posedge clk);
        #3;
        check("R8", "frm_rd in reset", int'(frm_rd), 0);
        check("R8", "outputs in reset",
              int'({chk_rd, pass_done, err_pulse, err_flag, scan_active, err_frame}), 0);
        do_reset();

        // table walk
        foreach (VECS[k]) begin
            string rq;
            do_reset();
            load(int'(VECS[k].seed));
            if (int'(VECS[k].flip_frm) != NONE) flip(int'(VECS[k].flip_frm), int'(VECS[k].flip_bit));
            start(int'(VECS[k].sel));
            wait_passes(1);
            rq = VECS[k].exp_err ? "R5" : "R4";
            check(rq, "err_flag", int'(err_flag), int'(VECS[k].exp_err));
            check(rq, "err_frame", int'(err_frame), int'(VECS[k].exp_frm));
            check("R5", "pulses in pass", pulse_cnt, int'(VECS[k].exp_err));
            check("R3", "address order", addr_err, 0);
            check("R2", "strobe spacing", gap_err, 0);
            check("R9", "compare latency", lat_err, 0);
            check("R1", "scan_active", int'(scan_active), 1);
        end

        // R1: gating by mode and enable
        do_reset();
        load(7);
        @(posedge clk); #1;
        user_mode = 1'b0; scrub_en = 1'b1;
        repeat (600) @(posedge clk);
        #3;
        check("R1", "reads without user_mode", rd_cnt, 0);
        check("R1", "scan_active without user_mode", int'(scan_active), 0);
        #1;
        user_mode = 1'b1; scrub_en = 1'b0;
        repeat (600) @(posedge clk);
        #3;
        check("R1", "reads without enable", rd_cnt, 0);

        // R1: stop mid-pass, restart from address 0
        start(0);
        repeat (30) @(posedge clk);
        #1 scrub_en = 1'b0;
        repeat (10) @(posedge clk);
        #1 scrub_en = 1'b1;
        wait_passes(1);
        check("R1", "restart address order", addr_err, 0);
        check("R1", "no stale compare after restart", int'(err_flag), 0);

        // R6: sticky flag, continued scanning after repair
        do_reset();
        load(9);
        flip(2, 4);
        start(1);
        wait_passes(1);
        check("R5", "flag after first pass", int'(err_flag), 1);
        flip(2, 4);
        wait_passes(2);
        check("R6", "second pass reached", pass_cnt, 2);
        check("R6", "no new pulse after repair", pulse_cnt, 1);
        check("R5", "flag stays set", int'(err_flag), 1);
        check("R5", "frame kept", int'(err_frame), 2);

        // R5: two failing frames, latest index kept
        do_reset();
        load(11);
        flip(1, 3);
        flip(4, 12);
        start(0);
        wait_passes(1);
        check("R5", "two pulses", pulse_cnt, 2);
        check("R5", "latest failing frame", int'(err_frame), 4);
        check("R9", "latency two errors", lat_err, 0);

        // R8: reset clears sticky state
        do_reset();
        #3;
        check("R8", "flag cleared by reset", int'(err_flag), 0);
        check("R8", "frame cleared by reset", int'(err_frame), 0);

        summary_and_end();
    end

endmodule